// File: doc/BRIEF.md
# Ethernet Transmit Serializer with Collision Jam

This block turns a frame held in a transmit FIFO into the serial bit stream of a 10 Mb/s Ethernet frame, one bit per clock. The clock is the internal transmit bit clock. A start pulse begins a frame. The block sends a 62-bit alternating preamble and a two-bit sync pattern. It then pulls data bytes from a show-ahead FIFO and shifts each one out least significant bit first, and it appends a 32-bit frame check sequence. The FCS is shifted directly out of the serial CRC register that absorbed every data bit.

A single pattern generator produces the preamble, the sync bits and the all-ones jam. When the collision input is seen during the preamble, data or FCS, the block abandons the frame and sends exactly 32 ones. It then drops transmit enable and pulses a collision-abort status. If the FIFO runs empty while bytes are still expected, the block finishes the byte in flight, ends the frame without an FCS and pulses an underrun status.

Top module: `tx_serial_framer`

## Requirements
- R1: While reset is high and on the cycle after it, tx_en, tx_bit, fifo_rd, frame_done, col_abort and underrun are all 0. Whenever tx_en is 0, tx_bit is 0.
- R2: A start pulse seen while idle raises tx_en on the next rising edge. The first 62 bits on tx_bit alternate, starting with 1 (1,0,1,0,...). Bits 62 and 63 are 1,1.
- R3: The FIFO is show-ahead: fifo_data and fifo_last are valid whenever fifo_empty is 0, and fifo_rd pops one byte. Each byte is sent least significant bit first, one bit per clock, directly after the sync bits or the previous byte. fifo_rd is high only while fifo_empty is 0.
- R4: After the byte flagged by fifo_last, 32 FCS bits follow. These bits are the complement of a CRC-32 (reflected polynomial 0xEDB88320, preset to all ones) taken over the data bits in the order they were sent. Bit 0 of the complemented value goes first. For the ASCII bytes "123456789" the FCS value is 0xCBF43926.
- R5: A completed frame is 64 + 8*N + 32 bits long. frame_done pulses for one cycle together with the last FCS bit, and tx_en falls on the next edge.
- R6: A collision seen during the preamble, sync, data or FCS lets the bit already due go out. Exactly 32 ones follow, including when the collision comes in the preamble. col_abort pulses with the last jam bit, tx_en then falls, and frame_done does not pulse.
- R7: A collision while idle or during the jam has no effect: no bits are sent, and the jam keeps its 32-bit length.
- R8: If the FIFO is empty when a byte is needed, the block sends the remaining bits of the current byte (or nothing after the sync). underrun pulses for one cycle, tx_en then falls, and no FCS is sent.
- R9: A start pulse during a frame is ignored, and the frame keeps its length and content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send a frame |
| collision | input | 1 | Collision indication, sampled every clock |
| fifo_data | input | 8 | Head byte of the transmit FIFO |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_last | input | 1 | Head byte is the final byte of the frame |
| fifo_rd | output | 1 | Pop the head byte |
| tx_bit | output | 1 | Serial transmit data (registered) |
| tx_en | output | 1 | Transmit enable (registered) |
| frame_done | output | 1 | One-cycle pulse: frame ended with FCS |
| col_abort | output | 1 | One-cycle pulse: frame ended with jam |
| underrun | output | 1 | One-cycle pulse: frame ended by empty FIFO |

## Verification
The assertions rely on the FIFO behaving as show-ahead storage. Its head byte and last flag must stay valid while it is not empty, and it may advance only on fifo_rd. They also rely on start and collision being synchronous inputs. The bench meets this with a FIFO model that pops only on the clock edge where fifo_rd is high. All of its inputs are driven on falling edges, and each frame is loaded only while the block is idle.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PRE  = 3'd1,
    S_DATA = 3'd2,
    S_FCS  = 3'd3,
    S_JAM  = 3'd4
  } txs_state_t;

  localparam logic [31:0] CRC32_POLY_REFL = 32'hEDB88320;
endpackage

// File: rtl/tx_pattern_gen.sv
module tx_pattern_gen #(
  parameter int PRE_BITS = 62,
  parameter int CNT_W    = 6
) (
  input  logic             jam,
  input  logic [CNT_W-1:0] cnt,
  output logic             pat_bit
);
  // Alternating 1,0 for the preamble, ones for the sync bits and the jam.
  always_comb begin
    if (jam)
      pat_bit = 1'b1;
    else if (int'(cnt) >= PRE_BITS)
      pat_bit = 1'b1;
    else
      pat_bit = ~cnt[0];
  end
endmodule

// File: rtl/tx_crc_serial.sv
module tx_crc_serial #(
  parameter int          W    = 32,
  parameter logic [W-1:0] POLY = 32'hEDB88320
) (
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic feed,
  input  logic shift,
  input  logic din,
  output logic fcs_bit
);
  logic [W-1:0] crc_q;

  // The low bit of the reflected register is the highest-order term.
  assign fcs_bit = ~crc_q[0];

  always_ff @(posedge clk) begin
    if (rst || init)
      crc_q <= '1;
    else if (feed)
      crc_q <= (crc_q >> 1) ^ ((crc_q[0] ^ din) ? POLY : '0);
    else if (shift)
      crc_q <= {1'b1, crc_q[W-1:1]};
  end
endmodule

// File: rtl/tx_byte_shifter.sv
module tx_byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  assign bit_o = sh_q[0];

  always_ff @(posedge clk) begin
    if (rst)
      sh_q <= '0;
    else if (load)
      sh_q <= din;
    else if (shift)
      sh_q <= {1'b0, sh_q[W-1:1]};
  end
endmodule

// File: rtl/tx_serial_framer.sv
module tx_serial_framer #(
  parameter int DATA_W    = 8,
  parameter int PRE_BITS  = 62,
  parameter int SYNC_BITS = 2,
  parameter int FCS_BITS  = 32,
  parameter int JAM_BITS  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              collision,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_empty,
  input  logic              fifo_last,
  output logic              fifo_rd,
  output logic              tx_bit,
  output logic              tx_en,
  output logic              frame_done,
  output logic              col_abort,
  output logic              underrun
);
  import txs_pkg::*;

  localparam int HDR_BITS = PRE_BITS + SYNC_BITS;
  localparam int MAX_A    = (HDR_BITS > FCS_BITS) ? HDR_BITS : FCS_BITS;
  localparam int MAX_CNT  = (MAX_A > JAM_BITS) ? MAX_A : JAM_BITS;
  localparam int CNT_W    = $clog2(MAX_CNT);
  localparam int BPOS_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  txs_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BPOS_W-1:0] bpos_q;
  logic              last_q;

  logic pat_bit, sh_bit, fcs_bit, cur_bit;
  logic live, hit, load_pt, hdr_end, byte_end;

  assign live     = (state_q == S_PRE) || (state_q == S_DATA) || (state_q == S_FCS);
  assign hit      = collision && live;
  assign hdr_end  = (state_q == S_PRE) && (cnt_q == CNT_W'(HDR_BITS - 1));
  assign byte_end = (state_q == S_DATA) && (bpos_q == BPOS_W'(DATA_W - 1));
  assign load_pt  = hdr_end || (byte_end && !last_q);
  assign fifo_rd  = load_pt && !hit && !fifo_empty;

  tx_pattern_gen #(.PRE_BITS(PRE_BITS), .CNT_W(CNT_W)) u_pat (
    .jam(state_q == S_JAM), .cnt(cnt_q), .pat_bit(pat_bit)
  );

  tx_byte_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(fifo_rd),
    .shift(state_q == S_DATA), .din(fifo_data), .bit_o(sh_bit)
  );

  tx_crc_serial #(.W(32), .POLY(CRC32_POLY_REFL)) u_crc (
    .clk(clk), .rst(rst), .init(state_q == S_IDLE),
    .feed(state_q == S_DATA), .shift(state_q == S_FCS),
    .din(sh_bit), .fcs_bit(fcs_bit)
  );

  always_comb begin
    unique case (state_q)
      S_PRE, S_JAM: cur_bit = pat_bit;
      S_DATA:       cur_bit = sh_bit;
      S_FCS:        cur_bit = fcs_bit;
      default:      cur_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      bpos_q     <= '0;
      last_q     <= 1'b0;
      tx_bit     <= 1'b0;
      tx_en      <= 1'b0;
      frame_done <= 1'b0;
      col_abort  <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      tx_bit     <= cur_bit;
      tx_en      <= (state_q != S_IDLE);
      frame_done <= 1'b0;
      col_abort  <= 1'b0;
      underrun   <= 1'b0;
      if (fifo_rd) last_q <= fifo_last;

      if (hit) begin
        state_q <= S_JAM;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          S_IDLE: if (start) begin
            state_q <= S_PRE;
            cnt_q   <= '0;
          end
          S_PRE: begin
            if (hdr_end) begin
              if (fifo_empty) begin
                state_q  <= S_IDLE;
                underrun <= 1'b1;
              end else begin
                state_q <= S_DATA;
                bpos_q  <= '0;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_DATA: begin
            if (byte_end) begin
              bpos_q <= '0;
              if (last_q) begin
                state_q <= S_FCS;
                cnt_q   <= '0;
              end else if (fifo_empty) begin
                state_q  <= S_IDLE;
                underrun <= 1'b1;
              end
            end else begin
              bpos_q <= bpos_q + 1'b1;
            end
          end
          S_FCS: begin
            if (cnt_q == CNT_W'(FCS_BITS - 1)) begin
              state_q    <= S_IDLE;
              frame_done <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_JAM: begin
            if (cnt_q == CNT_W'(JAM_BITS - 1)) begin
              state_q   <= S_IDLE;
              col_abort <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tx_serial_framer_chk.sv
module tx_serial_framer_chk #(
  parameter int JAM_BITS = 32
) (
  input logic clk,
  input logic rst,
  input logic fifo_empty,
  input logic fifo_rd,
  input logic tx_bit,
  input logic tx_en,
  input logic frame_done,
  input logic col_abort,
  input logic underrun
);
  localparam int RUN_W = $clog2(JAM_BITS + 1) + 1;
  logic [RUN_W-1:0] ones_run;

  always_ff @(posedge clk) begin
    if (rst)
      ones_run <= '0;
    else if (tx_en && tx_bit) begin
      if (ones_run != '1) ones_run <= ones_run + 1'b1;
    end else
      ones_run <= '0;
  end

  // R1: the line is quiet whenever transmit enable is low
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> !tx_bit);

  // R2: the first bit of every frame is a one
  assert_first_one_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> tx_bit);

  // R3: a pop only from a non-empty FIFO, and only while sending
  assert_rd_nonempty_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> (!fifo_empty && tx_en));

  // R5: end-of-frame pulses are exclusive
  assert_one_end_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_done, col_abort, underrun}));

  // R5: transmit enable falls right after any end pulse
  assert_end_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (frame_done || col_abort || underrun) |=> !tx_en);

  // R6: an abort is preceded by a full run of jam ones
  assert_jam_run_R6: assert property (@(posedge clk) disable iff (rst)
    col_abort |-> (tx_en && tx_bit && (int'(ones_run) >= JAM_BITS - 1)));
endmodule

bind tx_serial_framer tx_serial_framer_chk #(.JAM_BITS(JAM_BITS)) u_chk (
  .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
  .tx_bit(tx_bit), .tx_en(tx_en), .frame_done(frame_done),
  .col_abort(col_abort), .underrun(underrun)
);

// File: tb/sim_tx_serial_framer.sv
`timescale 1ns/1ps
module sim_tx_serial_framer;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, collision = 1'b0;
  logic [7:0] fifo_data;
  logic fifo_empty, fifo_last, fifo_rd, tx_bit, tx_en, frame_done, col_abort, underrun;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  // show-ahead FIFO model
  logic [7:0] fmem [0:255];
  int   fcount = 0;
  logic flast_en = 1'b0;
  logic fclr = 1'b0;
  int   rd_ptr = 0;
  always @(posedge clk) begin
    if (fclr) rd_ptr <= 0;
    else if (fifo_rd) rd_ptr <= rd_ptr + 1;
  end
  assign fifo_empty = (rd_ptr >= fcount);
  assign fifo_data  = fmem[rd_ptr[7:0]];
  assign fifo_last  = flast_en && (rd_ptr == fcount - 1);

  tx_serial_framer u0 (
    .clk(clk), .rst(rst), .start(start), .collision(collision),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_last(fifo_last),
    .fifo_rd(fifo_rd), .tx_bit(tx_bit), .tx_en(tx_en),
    .frame_done(frame_done), .col_abort(col_abort), .underrun(underrun)
  );

  // frame table: byte count and seed of the byte pattern
  localparam int NV = 6;
  localparam int VLEN [NV] = '{1, 2, 4, 7, 16, 60};
  localparam int VSEED[NV] = '{8'h5A, 8'h01, 8'hC3, 8'h77, 8'h10, 8'hE9};

  bit cap [0:1023];
  bit exp [0:1023];
  int cap_n, exp_n;
  bit saw_done, saw_col, saw_und;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic fill(input int n, input int seed, input bit last_on);
    @(negedge clk) fclr = 1'b1;
    @(negedge clk) fclr = 1'b0;
    for (int i = 0; i < n; i++) fmem[i] = 8'(seed * 7 + i * 29 + (i >> 2));
    fcount   = n;
    flast_en = last_on;
  endtask

  function automatic logic [31:0] ref_fcs(input int n);
    logic [31:0] c = '1;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ fmem[i][b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return ~c;
  endfunction

  task automatic build_exp(input int n, input bit with_fcs);
    logic [31:0] f;
    exp_n = 0;
    for (int i = 0; i < 62; i++) begin exp[exp_n] = (i % 2 == 0); exp_n++; end
    exp[exp_n] = 1'b1; exp_n++;
    exp[exp_n] = 1'b1; exp_n++;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin exp[exp_n] = fmem[i][b]; exp_n++; end
    if (with_fcs) begin
      f = ref_fcs(n);
      for (int b = 0; b < 32; b++) begin exp[exp_n] = f[b]; exp_n++; end
    end
  endtask

  // col1/col2/restart: raise that input after this many bits were seen (0 = never)
  task automatic run(input int col1, input int col2, input int restart);
    bit hi = 1'b0;
    cap_n = 0; saw_done = 0; saw_col = 0; saw_und = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      collision = 1'b0;
      start     = 1'b0;
      if (frame_done) saw_done = 1;
      if (col_abort)  saw_col  = 1;
      if (underrun)   saw_und  = 1;
      if (tx_en) begin
        hi = 1'b1;
        cap[cap_n] = tx_bit;
        cap_n++;
        if (cap_n == col1 || cap_n == col2) collision = 1'b1;
        if (cap_n == restart) start = 1'b1;
      end else if (hi) break;
    end
    collision = 1'b0;
    start     = 1'b0;
  endtask

  function automatic int mism(input int lo, input int hi);
    int m = 0;
    for (int i = lo; i < hi; i++) if (cap[i] != exp[i]) m++;
    return m;
  endfunction

  function automatic int zeros(input int lo, input int hi);
    int m = 0;
    for (int i = lo; i < hi; i++) if (!cap[i]) m++;
    return m;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] got;
    bit seen;
    int n;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!tx_en && !tx_bit && !fifo_rd, "R1", "outputs in reset", {tx_en, tx_bit, fifo_rd}, 0);
    chk(!frame_done && !col_abort && !underrun, "R1", "pulses in reset",
        {frame_done, col_abort, underrun}, 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(!tx_en && !tx_bit, "R1", "idle after reset", {tx_en, tx_bit}, 0);

    // R7: collision while idle
    collision = 1'b1;
    @(negedge clk) collision = 1'b0;
    seen = 0;
    repeat (40) begin @(negedge clk); if (tx_en || col_abort) seen = 1; end
    chk(!seen, "R7", "idle collision activity", seen, 0);

    // table of frames: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      n = VLEN[v];
      fill(n, VSEED[v], 1'b1);
      build_exp(n, 1'b1);
      run(0, 0, 0);
      chk(cap_n == 64 + 8 * n + 32, "R5", "frame length", cap_n, 64 + 8 * n + 32);
      chk(mism(0, 64) == 0, "R2", "preamble/sync mismatches", mism(0, 64), 0);
      chk(mism(64, 64 + 8 * n) == 0, "R3", "data mismatches", mism(64, 64 + 8 * n), 0);
      chk(mism(64 + 8 * n, exp_n) == 0, "R4", "fcs mismatches", mism(64 + 8 * n, exp_n), 0);
      chk(saw_done && !saw_col && !saw_und, "R5", "end pulses", {saw_done, saw_col, saw_und}, 4);
    end

    // R4: known check value
    fill(9, 0, 1'b1);
    for (int i = 0; i < 9; i++) fmem[i] = 8'h31 + 8'(i);
    run(0, 0, 0);
    for (int b = 0; b < 32; b++) got[b] = cap[136 + b];
    chk(got == 32'hCBF43926, "R4", "fcs of 123456789", got, 32'hCBF43926);

    // R6: collision in the preamble
    fill(5, 3, 1'b1);
    build_exp(5, 1'b1);
    run(10, 0, 0);
    chk(cap_n == 43, "R6", "preamble jam length", cap_n, 43);
    chk(mism(0, 11) == 0, "R6", "bits before jam", mism(0, 11), 0);
    chk(zeros(11, 43) == 0, "R6", "jam zeros", zeros(11, 43), 0);
    chk(saw_col && !saw_done, "R6", "abort pulse", {saw_col, saw_done}, 2);

    // R6 R7: collision in data, second collision inside the jam
    fill(6, 9, 1'b1);
    build_exp(6, 1'b1);
    run(84, 90, 0);
    chk(cap_n == 85 + 32, "R7", "jam length with repeat collision", cap_n, 117);
    chk(mism(0, 85) == 0 && zeros(85, 117) == 0, "R6", "data jam stream",
        mism(0, 85) + zeros(85, 117), 0);

    // R6: collision in the FCS
    fill(4, 2, 1'b1);
    build_exp(4, 1'b1);
    run(106, 0, 0);
    chk(cap_n == 139 && mism(0, 107) == 0 && zeros(107, 139) == 0, "R6", "fcs jam",
        cap_n, 139);
    chk(saw_col && !saw_done, "R6", "fcs abort pulse", {saw_col, saw_done}, 2);

    // R8: underrun after three bytes
    fill(3, 4, 1'b0);
    build_exp(3, 1'b0);
    run(0, 0, 0);
    chk(cap_n == 88, "R8", "underrun length", cap_n, 88);
    chk(mism(0, 88) == 0, "R8", "underrun stream", mism(0, 88), 0);
    chk(saw_und && !saw_done, "R8", "underrun pulse", {saw_und, saw_done}, 2);

    // R8: empty FIFO at the end of the sync
    fill(0, 0, 1'b0);
    run(0, 0, 0);
    chk(cap_n == 64 && saw_und, "R8", "empty frame length", cap_n, 64);

    // R9: start during a frame
    fill(5, 6, 1'b1);
    build_exp(5, 1'b1);
    run(0, 0, 30);
    chk(cap_n == 136, "R9", "length with restart", cap_n, 136);
    chk(mism(0, 136) == 0, "R9", "stream with restart", mism(0, 136), 0);
    repeat (5) @(negedge clk);
    chk(!tx_en, "R9", "idle after restart frame", tx_en, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule